// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block sits beside a data cache and takes over cache misses so that the cache never has to block. It can hold up to four line misses at the same time. For each miss it sends one request to the memory side. It then collects the four 64-bit double-word beats that make up a 32-byte line. As soon as the requested double word arrives, it is handed back to the requester, before the rest of the line has come in. When the line is complete, the block writes it into the cache array in a single cycle, together with its coherency state.

The load/store side offers a miss as a double-word address, a requester tag and a store flag. The block either opens a new fill entry for it or joins it to an entry that already holds the same line. If neither is possible, it holds the miss off with `miss_ready`. The memory side returns beats tagged with the entry number. Beats start at the requested double word and wrap around the line. Because the entries work independently, the cache keeps serving hits while one or more lines reload.

Top module: `cwf_line_fill`

## Requirements
- R1: After reset no entry is busy: `miss_ready` is 1 and `bus_req_valid`, `fwd_valid`, `wr_valid` and `join_valid` are 0.
- R2: An accepted miss whose line matches no entry takes the lowest-numbered free entry. When several entries wait for the bus, the lowest-numbered one drives `bus_req_valid`. It presents its number on `bus_req_id` and its double-word address {line, critical index} on `bus_req_addr`. The entry leaves the waiting state in the cycle `bus_req_ready` is 1.
- R3: An entry's four beats are stored at double-word indices crit, crit+1, crit+2 and crit+3 modulo 4. The cycle after the first (critical) beat, `fwd_valid` is 1 with the requester tag on `fwd_tag` and that beat on `fwd_data`.
- R4: The cycle after an entry's fourth beat, `wr_valid` is 1 for exactly one cycle. In that cycle `wr_line` carries the line address, and `wr_data` carries double word i at bits [64i+63:64i].
- R5: `wr_state` uses the encoding 2'b01 = Exclusive if neither the original miss nor any joined miss was a store, and 2'b10 = Modified otherwise. 2'b00 = Invalid is never written.
- R6: When no entry is free and the miss matches no entry, `miss_ready` is 0 and nothing is allocated. With fewer than four entries busy, a non-matching miss is always accepted.
- R7: An entry in its write cycle counts as free. A new miss in that same cycle takes it, and its request follows on the next cycle.
- R8: A miss to a line held by an entry that is still waiting for the bus or still filling, with no joined requester yet, is accepted without allocating a second entry. In the entry's write cycle, `join_valid` is 1 with the joined tag on `join_tag` and the requested double word on `join_data`.
- R9: A miss is held off (`miss_ready` = 0) if its line matches an entry that is in its write cycle or already has a joined requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss offered |
| miss_dwaddr | input | 29 | Double-word address of the miss {line[26:0], dw index[1:0]} |
| miss_tag | input | 6 | Requester tag |
| miss_store | input | 1 | Miss comes from a store |
| miss_ready | output | 1 | Miss accepted this cycle when valid |
| bus_req_valid | output | 1 | Line request to memory |
| bus_req_id | output | 2 | Entry number of the request |
| bus_req_addr | output | 29 | Critical double-word address of the request |
| bus_req_ready | input | 1 | Memory takes the request |
| beat_valid | input | 1 | A beat is returned |
| beat_id | input | 2 | Entry the beat belongs to |
| beat_data | input | 64 | Beat payload |
| fwd_valid | output | 1 | Critical double word forwarded |
| fwd_tag | output | 6 | Tag of the forwarded requester |
| fwd_data | output | 64 | Forwarded double word |
| wr_valid | output | 1 | Line write to the array |
| wr_line | output | 27 | Line address written |
| wr_data | output | 256 | Full line, double word i at [64i+63:64i] |
| wr_state | output | 2 | Installed coherency state |
| join_valid | output | 1 | Joined requester served |
| join_tag | output | 6 | Tag of the joined requester |
| join_data | output | 64 | Double word asked for by the joined requester |

## Verification
The assertions assume that memory behaves well. It returns beats only to an entry whose request it has taken, exactly four per entry, at most one beat per cycle, and with a `beat_id` that names an entry still filling. The bench plays the memory side from its own model of the entries. It only sends a beat to an entry the model holds in the filling state with beats still owed, and it builds each payload from the line address and the double-word index. Misses come from a small pool of lines with random tags, store flags and critical indices. This forces joins, stalls on a full buffer, and reuse of an entry in its write cycle.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

    localparam int ADDR_W    = 32;
    localparam int DW_W      = 64;
    localparam int BEATS     = 4;
    localparam int N_ENT     = 4;
    localparam int TAG_W     = 6;

    localparam int BIDX_W    = $clog2(BEATS);
    localparam int OFF_W     = $clog2(BEATS * DW_W / 8);
    localparam int LINE_W    = ADDR_W - OFF_W;
    localparam int DWA_W     = LINE_W + BIDX_W;
    localparam int EID_W     = $clog2(N_ENT);
    localparam int LINE_BITS = BEATS * DW_W;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_REQ   = 2'd1,
        FS_FILL  = 2'd2,
        FS_WRITE = 2'd3
    } fill_st_e;

    typedef enum logic [1:0] {
        MEI_I = 2'b00,
        MEI_E = 2'b01,
        MEI_M = 2'b10
    } mei_e;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [BIDX_W-1:0] crit;
        logic [TAG_W-1:0]  tag;
        logic              store;
    } miss_t;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [BIDX_W-1:0] idx;
    } waiter_t;

    function automatic logic [BIDX_W-1:0] wrap_idx(input logic [BIDX_W-1:0] crit,
                                                   input logic [BIDX_W-1:0] cnt);
        return crit + cnt;
    endfunction

    function automatic mei_e install_state(input logic dirty);
        return dirty ? MEI_M : MEI_E;
    endfunction

endpackage

// File: rtl/lfb_pick.sv
module lfb_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end

    assign any = |req;
endmodule

// File: rtl/lfb_entry.sv
module lfb_entry
    import lfb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc_i,
    input  miss_t                 new_i,
    input  logic                  join_i,
    input  waiter_t               join_w_i,
    input  logic                  join_store_i,
    input  logic                  grant_i,
    input  logic                  beat_i,
    input  logic [DW_W-1:0]       beat_data_i,
    output fill_st_e              state_o,
    output logic [LINE_W-1:0]     line_o,
    output logic [BIDX_W-1:0]     crit_o,
    output logic [TAG_W-1:0]      tag_o,
    output logic                  dirty_o,
    output waiter_t               waiter_o,
    output logic [LINE_BITS-1:0]  data_o,
    output logic                  first_beat_o
);
    localparam logic [BIDX_W-1:0] LAST_CNT = BIDX_W'(BEATS - 1);

    fill_st_e          state_q;
    miss_t             req_q;
    logic [BIDX_W-1:0] cnt_q;
    logic              dirty_q;
    waiter_t           wait_q;
    logic [DW_W-1:0]   buf_q [BEATS];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            req_q   <= '0;
            cnt_q   <= '0;
            dirty_q <= 1'b0;
            wait_q  <= '0;
        end else begin
            case (state_q)
                FS_IDLE, FS_WRITE: begin
                    if (alloc_i) begin
                        state_q <= FS_REQ;
                        req_q   <= new_i;
                        dirty_q <= new_i.store;
                        cnt_q   <= '0;
                        wait_q  <= '0;
                    end else begin
                        state_q <= FS_IDLE;
                        wait_q  <= '0;
                    end
                end
                FS_REQ: begin
                    if (grant_i) state_q <= FS_FILL;
                end
                FS_FILL: begin
                    if (beat_i) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST_CNT) state_q <= FS_WRITE;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
            if (join_i && (state_q == FS_REQ || state_q == FS_FILL)) begin
                wait_q  <= join_w_i;
                dirty_q <= dirty_q | join_store_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (beat_i && state_q == FS_FILL)
            buf_q[wrap_idx(req_q.crit, cnt_q)] <= beat_data_i;
    end

    for (genvar b = 0; b < BEATS; b++) begin : g_pack
        assign data_o[b*DW_W +: DW_W] = buf_q[b];
    end

    assign state_o      = state_q;
    assign line_o       = req_q.line;
    assign crit_o       = req_q.crit;
    assign tag_o        = req_q.tag;
    assign dirty_o      = dirty_q;
    assign waiter_o     = wait_q;
    assign first_beat_o = beat_i && state_q == FS_FILL && cnt_q == '0;

    AST_BEAT_ONLY_FILL: assert property (@(posedge clk) disable iff (rst)
        beat_i |-> state_q == FS_FILL); // R3
    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        state_q == FS_WRITE |=> state_q != FS_WRITE); // R4
    AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (rst)
        grant_i |-> state_q == FS_REQ); // R2
    AST_JOIN_ONCE: assert property (@(posedge clk) disable iff (rst)
        join_i |-> !wait_q.valid); // R9
    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc_i |-> (state_q == FS_IDLE || state_q == FS_WRITE)); // R7
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
    import lfb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 miss_valid,
    input  logic [DWA_W-1:0]     miss_dwaddr,
    input  logic [TAG_W-1:0]     miss_tag,
    input  logic                 miss_store,
    output logic                 miss_ready,
    output logic                 bus_req_valid,
    output logic [EID_W-1:0]     bus_req_id,
    output logic [DWA_W-1:0]     bus_req_addr,
    input  logic                 bus_req_ready,
    input  logic                 beat_valid,
    input  logic [EID_W-1:0]     beat_id,
    input  logic [DW_W-1:0]      beat_data,
    output logic                 fwd_valid,
    output logic [TAG_W-1:0]     fwd_tag,
    output logic [DW_W-1:0]      fwd_data,
    output logic                 wr_valid,
    output logic [LINE_W-1:0]    wr_line,
    output logic [LINE_BITS-1:0] wr_data,
    output logic [1:0]           wr_state,
    output logic                 join_valid,
    output logic [TAG_W-1:0]     join_tag,
    output logic [DW_W-1:0]      join_data
);
    fill_st_e             ent_st    [N_ENT];
    logic [LINE_W-1:0]    ent_line  [N_ENT];
    logic [BIDX_W-1:0]    ent_crit  [N_ENT];
    logic [TAG_W-1:0]     ent_tag   [N_ENT];
    logic                 ent_dirty [N_ENT];
    waiter_t              ent_wait  [N_ENT];
    logic [LINE_BITS-1:0] ent_data  [N_ENT];

    logic [N_ENT-1:0] first_vec, match_vec, free_vec, live_vec, wait_vec;
    logic [N_ENT-1:0] reqst_vec, write_vec, alloc_gnt, bus_gnt, alloc_vec, join_vec, beat_vec;
    logic             any_free, any_bus, any_match, match_ok, alloc_go, join_go;

    miss_t   new_miss;
    waiter_t new_wait;

    assign new_miss.line  = miss_dwaddr[DWA_W-1:BIDX_W];
    assign new_miss.crit  = miss_dwaddr[BIDX_W-1:0];
    assign new_miss.tag   = miss_tag;
    assign new_miss.store = miss_store;
    assign new_wait.valid = 1'b1;
    assign new_wait.tag   = miss_tag;
    assign new_wait.idx   = miss_dwaddr[BIDX_W-1:0];

    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            live_vec[i]  = ent_st[i] == FS_REQ || ent_st[i] == FS_FILL;
            free_vec[i]  = ent_st[i] == FS_IDLE || ent_st[i] == FS_WRITE;
            reqst_vec[i] = ent_st[i] == FS_REQ;
            write_vec[i] = ent_st[i] == FS_WRITE;
            wait_vec[i]  = ent_wait[i].valid;
            match_vec[i] = ent_st[i] != FS_IDLE && ent_line[i] == new_miss.line;
            beat_vec[i]  = beat_valid && beat_id == EID_W'(i);
        end
    end

    lfb_pick #(.N(N_ENT)) u_alloc_pick (.req(free_vec),  .gnt(alloc_gnt), .any(any_free));
    lfb_pick #(.N(N_ENT)) u_bus_pick   (.req(reqst_vec), .gnt(bus_gnt),   .any(any_bus));

    assign any_match  = |match_vec;
    assign match_ok   = |(match_vec & live_vec & ~wait_vec);
    assign miss_ready = any_match ? match_ok : any_free;
    assign alloc_go   = miss_valid && !any_match && any_free;
    assign join_go    = miss_valid && any_match && match_ok;
    assign alloc_vec  = alloc_go ? alloc_gnt : '0;
    assign join_vec   = join_go ? match_vec : '0;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        lfb_entry u_ent (
            .clk          (clk),
            .rst          (rst),
            .alloc_i      (alloc_vec[g]),
            .new_i        (new_miss),
            .join_i       (join_vec[g]),
            .join_w_i     (new_wait),
            .join_store_i (miss_store),
            .grant_i      (bus_gnt[g] && bus_req_ready),
            .beat_i       (beat_vec[g]),
            .beat_data_i  (beat_data),
            .state_o      (ent_st[g]),
            .line_o       (ent_line[g]),
            .crit_o       (ent_crit[g]),
            .tag_o        (ent_tag[g]),
            .dirty_o      (ent_dirty[g]),
            .waiter_o     (ent_wait[g]),
            .data_o       (ent_data[g]),
            .first_beat_o (first_vec[g])
        );
    end

    // Bus request and line-write multiplexers.
    always_comb begin
        bus_req_valid = any_bus;
        bus_req_id    = '0;
        bus_req_addr  = '0;
        wr_valid      = 1'b0;
        wr_line       = '0;
        wr_data       = '0;
        wr_state      = MEI_I;
        join_valid    = 1'b0;
        join_tag      = '0;
        join_data     = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (bus_gnt[i]) begin
                bus_req_id   = EID_W'(i);
                bus_req_addr = {ent_line[i], ent_crit[i]};
            end
            if (write_vec[i]) begin
                wr_valid   = 1'b1;
                wr_line    = ent_line[i];
                wr_data    = ent_data[i];
                wr_state   = install_state(ent_dirty[i]);
                join_valid = ent_wait[i].valid;
                join_tag   = ent_wait[i].tag;
                join_data  = ent_data[i][ent_wait[i].idx*DW_W +: DW_W];
            end
        end
    end

    // Critical double word is forwarded the cycle after it lands.
    logic [TAG_W-1:0] first_tag;
    always_comb begin
        first_tag = '0;
        for (int i = 0; i < N_ENT; i++)
            if (first_vec[i]) first_tag = ent_tag[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_valid <= 1'b0;
            fwd_tag   <= '0;
            fwd_data  <= '0;
        end else begin
            fwd_valid <= |first_vec;
            if (|first_vec) begin
                fwd_tag  <= first_tag;
                fwd_data <= beat_data;
            end
        end
    end

    // Checker-side view: two live entries must never share a line.
    logic dup_live;
    always_comb begin
        dup_live = 1'b0;
        for (int i = 0; i < N_ENT; i++)
            for (int j = i + 1; j < N_ENT; j++)
                if (live_vec[i] && live_vec[j] && ent_line[i] == ent_line[j])
                    dup_live = 1'b1;
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(write_vec)); // R4
    AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (rst)
        !dup_live); // R8
    AST_FWD_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> $past(beat_valid)); // R3
    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && !miss_ready && !any_match) |-> $countones(live_vec) == N_ENT); // R6
    AST_STATE_NOT_INVALID: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> wr_state != MEI_I); // R5
endmodule

// File: tb/cwf_line_fill_test.sv
module cwf_line_fill_test;
    localparam int CLK_PERIOD = 10;
    localparam int SEED = 32'h5eed_1234;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic miss_valid = 1'b0;
    logic [28:0] miss_dwaddr = '0;
    logic [5:0] miss_tag = '0;
    logic miss_store = 1'b0;
    logic miss_ready;
    logic bus_req_valid;
    logic [1:0] bus_req_id;
    logic [28:0] bus_req_addr;
    logic bus_req_ready = 1'b0;
    logic beat_valid = 1'b0;
    logic [1:0] beat_id = '0;
    logic [63:0] beat_data = '0;
    logic fwd_valid;
    logic [5:0] fwd_tag;
    logic [63:0] fwd_data;
    logic wr_valid;
    logic [26:0] wr_line;
    logic [255:0] wr_data;
    logic [1:0] wr_state;
    logic join_valid;
    logic [5:0] join_tag;
    logic [63:0] join_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    cwf_line_fill uut (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_dwaddr(miss_dwaddr), .miss_tag(miss_tag),
        .miss_store(miss_store), .miss_ready(miss_ready),
        .bus_req_valid(bus_req_valid), .bus_req_id(bus_req_id), .bus_req_addr(bus_req_addr),
        .bus_req_ready(bus_req_ready),
        .beat_valid(beat_valid), .beat_id(beat_id), .beat_data(beat_data),
        .fwd_valid(fwd_valid), .fwd_tag(fwd_tag), .fwd_data(fwd_data),
        .wr_valid(wr_valid), .wr_line(wr_line), .wr_data(wr_data), .wr_state(wr_state),
        .join_valid(join_valid), .join_tag(join_tag), .join_data(join_data)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Bench model of the entries: 0 idle, 1 waiting for bus, 2 filling, 3 writing.
    int          st [4];
    logic [26:0] ln [4];
    logic [1:0]  cr [4];
    logic [5:0]  tg [4];
    bit          dirty [4];
    bit          wv [4];
    logic [5:0]  wtg [4];
    logic [1:0]  wix [4];
    int          cnt [4];
    bit          exp_fv = 1'b0;
    logic [5:0]  exp_ftag = '0;
    logic [63:0] exp_fdata = '0;
    int          seen_r7 = 0;
    int          seen_join = 0;

    function automatic logic [63:0] dw_of(input logic [26:0] l, input logic [1:0] ix);
        return {l, 5'h15, ix, 30'(l * 7)};
    endfunction

    function automatic logic [255:0] line_of(input logic [26:0] l);
        logic [255:0] v;
        for (int i = 0; i < 4; i++) v[i*64 +: 64] = dw_of(l, 2'(i));
        return v;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        int w;
        int g;
        // R3: forward of the critical double word
        chk(fwd_valid == exp_fv, "R3", "fwd_valid", 256'(fwd_valid), 256'(exp_fv));
        if (exp_fv) begin
            chk(fwd_tag == exp_ftag, "R3", "fwd_tag", 256'(fwd_tag), 256'(exp_ftag));
            chk(fwd_data == exp_fdata, "R3", "fwd_data", 256'(fwd_data), 256'(exp_fdata));
        end
        w = -1;
        for (int s = 0; s < 4; s++) if (st[s] == 3) w = s;
        chk(wr_valid == (w >= 0), "R4", "wr_valid", 256'(wr_valid), 256'(w >= 0));
        if (w >= 0) begin
            chk(wr_line == ln[w], "R4", "wr_line", 256'(wr_line), 256'(ln[w]));
            chk(wr_data == line_of(ln[w]), "R4", "wr_data", wr_data, line_of(ln[w]));
            chk(wr_state == (dirty[w] ? 2'b10 : 2'b01), "R5", "wr_state",
                256'(wr_state), 256'(dirty[w] ? 2'b10 : 2'b01));
            chk(join_valid == wv[w], "R8", "join_valid", 256'(join_valid), 256'(wv[w]));
            if (wv[w]) begin
                seen_join++;
                chk(join_tag == wtg[w], "R8", "join_tag", 256'(join_tag), 256'(wtg[w]));
                chk(join_data == dw_of(ln[w], wix[w]), "R8", "join_data",
                    256'(join_data), 256'(dw_of(ln[w], wix[w])));
            end
        end else begin
            chk(join_valid == 1'b0, "R8", "join_valid idle", 256'(join_valid), 256'(0));
        end
        g = -1;
        for (int s = 3; s >= 0; s--) if (st[s] == 1) g = s;
        chk(bus_req_valid == (g >= 0), "R2", "bus_req_valid", 256'(bus_req_valid), 256'(g >= 0));
        if (g >= 0) begin
            chk(bus_req_id == 2'(g), "R2", "bus_req_id", 256'(bus_req_id), 256'(g));
            chk(bus_req_addr == {ln[g], cr[g]}, "R2", "bus_req_addr",
                256'(bus_req_addr), 256'({ln[g], cr[g]}));
        end
    endtask

    task automatic step(input int pm, input int pb);
        int ps [4];
        int m, a, g, bslot, start;
        bit exp_ready, full, usedw;
        logic [26:0] l;
        logic [1:0] c;
        check_outputs();
        // drive
        l = 27'h0100 + 27'($urandom % 6) * 27'h3;
        c = 2'($urandom);
        miss_valid  = ($urandom % 100) < pm;
        miss_dwaddr = {l, c};
        miss_tag    = 6'($urandom);
        miss_store  = ($urandom % 3) == 0;
        bus_req_ready = ($urandom % 4) != 0;
        bslot = -1;
        if (($urandom % 100) < pb) begin
            start = $urandom % 4;
            for (int k = 0; k < 4; k++) begin
                int s;
                s = (start + k) % 4;
                if (bslot < 0 && st[s] == 2) bslot = s;
            end
        end
        beat_valid = bslot >= 0;
        beat_id    = bslot >= 0 ? 2'(bslot) : 2'd0;
        beat_data  = bslot >= 0 ? dw_of(ln[bslot], 2'(cr[bslot] + 2'(cnt[bslot]))) : 64'd0;
        #1;
        for (int s = 0; s < 4; s++) ps[s] = st[s];
        m = -1;
        for (int s = 0; s < 4; s++) if (ps[s] != 0 && ln[s] == l) m = s;
        a = -1;
        for (int s = 3; s >= 0; s--) if (ps[s] == 0 || ps[s] == 3) a = s;
        full = 1'b1;
        usedw = 1'b0;
        for (int s = 0; s < 4; s++) if (ps[s] == 0) full = 1'b0;
        if (a >= 0 && ps[a] == 3) usedw = 1'b1;
        if (m >= 0) exp_ready = (ps[m] == 1 || ps[m] == 2) && !wv[m];
        else        exp_ready = a >= 0;
        if (miss_valid) begin
            if (m >= 0 && exp_ready)
                chk(miss_ready == exp_ready, "R8", "miss_ready join", 256'(miss_ready), 256'(exp_ready));
            else if (m >= 0)
                chk(miss_ready == exp_ready, "R9", "miss_ready held", 256'(miss_ready), 256'(exp_ready));
            else if (a < 0)
                chk(miss_ready == exp_ready, "R6", "miss_ready full", 256'(miss_ready), 256'(exp_ready));
            else if (full && usedw) begin
                seen_r7++;
                chk(miss_ready == exp_ready, "R7", "miss_ready reuse", 256'(miss_ready), 256'(exp_ready));
            end else
                chk(miss_ready == exp_ready, "R6", "miss_ready free", 256'(miss_ready), 256'(exp_ready));
        end
        // model update for the coming edge
        exp_fv = 1'b0;
        for (int s = 0; s < 4; s++) if (ps[s] == 3) begin st[s] = 0; wv[s] = 1'b0; end
        g = -1;
        for (int s = 3; s >= 0; s--) if (ps[s] == 1) g = s;
        if (g >= 0 && bus_req_ready) begin st[g] = 2; cnt[g] = 0; end
        if (bslot >= 0) begin
            if (cnt[bslot] == 0) begin
                exp_fv = 1'b1;
                exp_ftag = tg[bslot];
                exp_fdata = beat_data;
            end
            cnt[bslot]++;
            if (cnt[bslot] == 4) st[bslot] = 3;
        end
        if (miss_valid && exp_ready) begin
            if (m >= 0) begin
                wv[m] = 1'b1; wtg[m] = miss_tag; wix[m] = c;
                dirty[m] = dirty[m] | miss_store;
            end else begin
                st[a] = 1; ln[a] = l; cr[a] = c; tg[a] = miss_tag;
                dirty[a] = miss_store; wv[a] = 1'b0; cnt[a] = 0;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(SEED));
        for (int s = 0; s < 4; s++) begin
            st[s] = 0; ln[s] = '0; cr[s] = '0; tg[s] = '0; dirty[s] = 0;
            wv[s] = 0; wtg[s] = '0; wix[s] = '0; cnt[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #1;
        chk(miss_ready == 1'b1, "R1", "miss_ready", 256'(miss_ready), 256'(1));
        chk(bus_req_valid == 1'b0, "R1", "bus_req_valid", 256'(bus_req_valid), 256'(0));
        chk(fwd_valid == 1'b0, "R1", "fwd_valid", 256'(fwd_valid), 256'(0));
        chk(wr_valid == 1'b0, "R1", "wr_valid", 256'(wr_valid), 256'(0));
        chk(join_valid == 1'b0, "R1", "join_valid", 256'(join_valid), 256'(0));
        @(negedge clk);
        for (int i = 0; i < 1500; i++) step(85, 20);
        for (int i = 0; i < 3000; i++) step(45, 60);
        for (int i = 0; i < 1500; i++) step(90, 35);
        for (int i = 0; i < 200; i++) step(0, 100);
        chk(seen_r7 > 0, "R7", "reuse case reached", 256'(seen_r7), 256'(1));
        chk(seen_join > 0, "R8", "join served", 256'(seen_join), 256'(1));
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule